// File: doc/BRIEF.md
# HDLC Receive Pool Buffer

This block sits behind an HDLC deframer and takes the frame octets it delivers, one per strobe. It stores them in a ring of fixed-size pools (two pools of 32 octets by default). Each time a pool fills before the message has ended, the block sends the host a one-cycle block-ready pulse. The host then drains that pool through a byte-wide read port and frees it with a release command. When the deframer signals the end of a frame, the block raises a one-cycle message-end pulse. It then holds the byte count and the end-of-frame status until the host has released every pool that belongs to the message.

A single 12-bit counter gives the message length. The low count output carries the octets held in the last, partly filled pool and the low bits of the full-block count. The high count output carries the rest of the block count and a length-overflow flag. The status outputs report the CRC verdict supplied by the deframer, an abort, and a data overflow. A data overflow means octets were lost because the host had not freed a pool in time. A reset command throws away everything that is buffered.

Top module: `hdlc_rx_pool`

## Requirements
- R1: After rst_n low, and in the cycle after cmd_reset, cnt_lo and cnt_hi are zero and irq_block, irq_msg_end, msg_done, st_crc_ok, st_abort and st_data_ovf are 0.
- R2: Octets are stored in arrival order. rd_data shows the octet at the read pointer of the oldest unreleased pool. Each host_rd cycle advances that pointer by one.
- R3: irq_block is high for exactly one cycle, in the cycle after the one that stores the 32nd octet of a pool.
- R4: irq_msg_end is high for exactly one cycle, in the cycle after rx_end is accepted. msg_done is 1 from that cycle on.
- R5: The running octet count N of the current message is output as follows. cnt_lo[4:0] is N mod 32. {cnt_hi[3:0], cnt_lo[7:5]} is N / 32, the number of full blocks.
- R6: The count stops at 4095. When the 4096th octet arrives, cnt_hi[4] is set, and it stays set until the message is released.
- R7: st_crc_ok and st_abort take the values of rx_crc_ok and rx_abort in the cycle rx_end is accepted.
- R8: An octet that finds its target pool still unreleased is dropped and sets st_data_ovf. Every later octet of that message is dropped too, while counting goes on.
- R9: cmd_release frees the oldest occupied pool and resets the read pointer. It has no effect when no pool is occupied. Once the last pool of an ended message is freed, msg_done, the counts and the status outputs clear.
- R10: While msg_done is 1, rx_valid and rx_end are ignored: the counts, the status and msg_done do not change, and no interrupt is raised.
- R11: cmd_reset discards all buffered octets. The first octet of the next message is the first octet the host reads afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Octet strobe from the deframer |
| rx_data | input | 8 | Received octet |
| rx_end | input | 1 | End-of-frame strobe (never in the same cycle as rx_valid) |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_end |
| rx_abort | input | 1 | Abort seen (seven consecutive ones), valid with rx_end |
| host_rd | input | 1 | Host read strobe, advances the read pointer |
| cmd_release | input | 1 | Release the pool just read |
| cmd_reset | input | 1 | Discard all buffered data and status |
| rd_data | output | 8 | Octet at the read pointer |
| irq_block | output | 1 | One-cycle block-ready pulse |
| irq_msg_end | output | 1 | One-cycle message-end pulse |
| msg_done | output | 1 | Ended message awaiting release |
| cnt_lo | output | 8 | Residual octets [4:0] and low block count [7:5] |
| cnt_hi | output | 5 | High block count [3:0] and length overflow [4] |
| st_crc_ok | output | 1 | Latched CRC verdict |
| st_abort | output | 1 | Latched abort |
| st_data_ovf | output | 1 | Octets were dropped in this message |

## Verification
The bench builds the block with its default parameters: two pools of 32 octets, a 12-bit counter and an 8-bit low count field. At this size a 4100-octet message is enough to drive the counter into saturation and raise the length flag. With only two pools, holding back the host for 65 octets is enough to force a drop. The same pool size makes the exact 32-octet message reachable, which leaves an empty final pool that still has to be released.

// File: rtl/hrp_pkg.sv
// Package: shared types for the HDLC receive pool buffer.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package hrp_pkg;
    // End-of-frame status captured when the deframer closes a message
    typedef struct packed {
        logic crc_ok;
        logic abort;
    } end_stat_t;
endpackage

// File: rtl/hrp_pool_mem.sv
// Module: octet storage for all pools, one write port and one asynchronous
// read port. Assumes the controller never writes and reads the same address
// with conflicting intent; the storage itself carries no reset.
module hrp_pool_mem #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] store [DEPTH];

    // Write one octet per accepted strobe
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Present the octet at the host read address
    assign rd_data = store[rd_addr];
endmodule

// File: rtl/hrp_len_counter.sv
// Module: saturating message length counter with an overflow flag.
// Assumes clr has priority over inc and that rst_n is synchronous.
module hrp_len_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // Count accepted octets; on an increment at the top, hold and flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (inc) begin
            if (count == TOP) sat <= 1'b1;
            else              count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/hrp_pool_ctrl.sv
// Module: pool ring bookkeeping: write and read pool indices, offsets,
// per-pool occupancy, drop tracking, interrupt pulses and status latches.
// Assumes NUM_POOLS and POOL_BYTES are powers of two and that rx_end never
// coincides with rx_valid. Pools are released in ring order.
module hrp_pool_ctrl
    import hrp_pkg::*;
#(
    parameter int NUM_POOLS  = 2,
    parameter int POOL_BYTES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_end,
    input  logic rx_crc_ok,
    input  logic rx_abort,
    input  logic host_rd,
    input  logic cmd_release,
    input  logic cmd_reset,
    output logic wr_en,
    output logic [$clog2(NUM_POOLS)+$clog2(POOL_BYTES)-1:0] wr_addr,
    output logic [$clog2(NUM_POOLS)+$clog2(POOL_BYTES)-1:0] rd_addr,
    output logic cnt_inc,
    output logic cnt_clr,
    output logic irq_block,
    output logic irq_msg_end,
    output logic msg_done,
    output logic data_ovf,
    output end_stat_t end_stat
);
    localparam int POOL_W = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1;
    localparam int OFF_W  = $clog2(POOL_BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(POOL_BYTES - 1);

    logic [POOL_W-1:0]    wp_q, rp_q, rp_n;
    logic [OFF_W-1:0]     wr_off_q, rd_off_q;
    logic [NUM_POOLS-1:0] occ_q, set_v, clr_v, occ_kept;
    logic                 eom_q, drop_q, blk_q, end_q;
    end_stat_t            stat_q;

    logic take_oct, take_end, store_ok, drop_now, blk_full, rel_ok, final_rel;

    // Qualify deframer strobes and host commands against current state
    always_comb begin
        take_oct  = rx_valid && !eom_q;
        take_end  = rx_end && !eom_q;
        store_ok  = take_oct && !drop_q && !occ_q[wp_q];
        drop_now  = take_oct && !drop_q && occ_q[wp_q];
        blk_full  = store_ok && (wr_off_q == LAST_OFF);
        rel_ok    = cmd_release && occ_q[rp_q];
        rp_n      = rp_q + 1'b1;
        occ_kept  = occ_q & ~clr_v;
        final_rel = rel_ok && eom_q && (occ_kept == '0);
    end

    // Per-pool set and clear terms for the occupancy vector
    for (genvar g = 0; g < NUM_POOLS; g++) begin : g_pool
        assign set_v[g] = (blk_full || take_end) && (wp_q == POOL_W'(g));
        assign clr_v[g] = rel_ok && (rp_q == POOL_W'(g));
    end

    // Occupancy, indices and offsets of the pool ring
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            occ_q    <= '0;
            wp_q     <= '0;
            rp_q     <= '0;
            wr_off_q <= '0;
            rd_off_q <= '0;
        end else begin
            occ_q <= occ_kept | set_v;
            if (final_rel) begin
                wp_q     <= rp_n;
                wr_off_q <= '0;
            end else if (blk_full || take_end) begin
                wp_q     <= wp_q + 1'b1;
                wr_off_q <= '0;
            end else if (store_ok) begin
                wr_off_q <= wr_off_q + 1'b1;
            end
            if (rel_ok) begin
                rp_q     <= rp_n;
                rd_off_q <= '0;
            end else if (host_rd && occ_q[rp_q]) begin
                rd_off_q <= rd_off_q + 1'b1;
            end
        end
    end

    // Message-end, drop tracking and status capture
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            eom_q  <= 1'b0;
            drop_q <= 1'b0;
            stat_q <= '0;
        end else if (final_rel) begin
            eom_q  <= 1'b0;
            drop_q <= 1'b0;
            stat_q <= '0;
        end else begin
            if (drop_now) drop_q <= 1'b1;
            if (take_end) begin
                eom_q         <= 1'b1;
                stat_q.crc_ok <= rx_crc_ok;
                stat_q.abort  <= rx_abort;
            end
        end
    end

    // One-cycle interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            blk_q <= 1'b0;
            end_q <= 1'b0;
        end else begin
            blk_q <= blk_full;
            end_q <= take_end;
        end
    end

    assign wr_en       = store_ok;
    assign wr_addr     = {wp_q[POOL_W-1:0], wr_off_q};
    assign rd_addr     = {rp_q[POOL_W-1:0], rd_off_q};
    assign cnt_inc     = take_oct;
    assign cnt_clr     = cmd_reset || final_rel;
    assign irq_block   = blk_q;
    assign irq_msg_end = end_q;
    assign msg_done    = eom_q;
    assign data_ovf    = drop_q;
    assign end_stat    = stat_q;
endmodule

// File: rtl/hdlc_rx_pool.sv
// Module: top of the HDLC receive pool buffer. It joins storage, ring
// control and the length counter, and splits the count into the low and
// high count outputs. Assumes CNT_W > LO_W and LO_W > log2(POOL_BYTES).
module hdlc_rx_pool
    import hrp_pkg::*;
#(
    parameter int NUM_POOLS  = 2,
    parameter int POOL_BYTES = 32,
    parameter int CNT_W      = 12,
    parameter int LO_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_end,
    input  logic                 rx_crc_ok,
    input  logic                 rx_abort,
    input  logic                 host_rd,
    input  logic                 cmd_release,
    input  logic                 cmd_reset,
    output logic [7:0]           rd_data,
    output logic                 irq_block,
    output logic                 irq_msg_end,
    output logic                 msg_done,
    output logic [LO_W-1:0]      cnt_lo,
    output logic [CNT_W-LO_W:0]  cnt_hi,
    output logic                 st_crc_ok,
    output logic                 st_abort,
    output logic                 st_data_ovf
);
    localparam int ADDR_W = $clog2(NUM_POOLS) + $clog2(POOL_BYTES);

    logic              wr_en, cnt_inc, cnt_clr, len_sat;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  len_cnt;
    end_stat_t         end_stat;

    hrp_pool_ctrl #(
        .NUM_POOLS (NUM_POOLS),
        .POOL_BYTES(POOL_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_end     (rx_end),
        .rx_crc_ok  (rx_crc_ok),
        .rx_abort   (rx_abort),
        .host_rd    (host_rd),
        .cmd_release(cmd_release),
        .cmd_reset  (cmd_reset),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .cnt_inc    (cnt_inc),
        .cnt_clr    (cnt_clr),
        .irq_block  (irq_block),
        .irq_msg_end(irq_msg_end),
        .msg_done   (msg_done),
        .data_ovf   (st_data_ovf),
        .end_stat   (end_stat)
    );

    hrp_pool_mem #(
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(rx_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    hrp_len_counter #(
        .CNT_W(CNT_W)
    ) u_len (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .count(len_cnt),
        .sat  (len_sat)
    );

    // Split the length into the low field and the high field plus flag
    assign cnt_lo    = len_cnt[LO_W-1:0];
    assign cnt_hi    = {len_sat, len_cnt[CNT_W-1:LO_W]};
    assign st_crc_ok = end_stat.crc_ok;
    assign st_abort  = end_stat.abort;
endmodule

// File: rtl/hrp_checker.sv
// Module: temporal checks on the ports of hdlc_rx_pool, attached by bind.
// Assumes the synchronous active-low reset is held for at least one edge.
module hrp_checker #(
    parameter int CNT_W = 12,
    parameter int LO_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                rx_end,
    input logic                cmd_release,
    input logic                cmd_reset,
    input logic                irq_block,
    input logic                irq_msg_end,
    input logic                msg_done,
    input logic [LO_W-1:0]     cnt_lo,
    input logic [CNT_W-LO_W:0] cnt_hi,
    input logic                st_data_ovf
);
    localparam int HB = CNT_W - LO_W;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (cnt_lo == '0 && cnt_hi == '0 && !msg_done && !st_data_ovf));

    assert_block_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_block |=> !irq_block);

    assert_end_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_end |-> (msg_done && $past(rx_end)));

    assert_end_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_end |=> !irq_msg_end);

    assert_len_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hi[HB] |-> ((&cnt_lo) && (&cnt_hi[HB-1:0])));

    assert_drop_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_data_ovf) |-> $past(rx_valid));

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_done) |-> ($past(cmd_release) || $past(cmd_reset)));

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && !cmd_release && !cmd_reset) |=>
            (msg_done && $stable(cnt_lo) && $stable(cnt_hi) && !irq_block && !irq_msg_end));
endmodule

bind hdlc_rx_pool hrp_checker #(
    .CNT_W(CNT_W),
    .LO_W (LO_W)
) u_hrp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_end     (rx_end),
    .cmd_release(cmd_release),
    .cmd_reset  (cmd_reset),
    .irq_block  (irq_block),
    .irq_msg_end(irq_msg_end),
    .msg_done   (msg_done),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .st_data_ovf(st_data_ovf)
);

// File: tb/tb_hdlc_rx_pool.sv
// Bench: scoreboard for hdlc_rx_pool. The driver pushes every octet the
// block must keep into a queue; the host-read monitor pops and compares.
module tb_hdlc_rx_pool;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b0, rx_abort = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       host_rd = 1'b0, cmd_release = 1'b0, cmd_reset = 1'b0;
    logic [7:0] rd_data, cnt_lo;
    logic [4:0] cnt_hi;
    logic       irq_block, irq_msg_end, msg_done, st_crc_ok, st_abort, st_data_ovf;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] expq[$];

    always #10 clk = ~clk;

    hdlc_rx_pool dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .rx_abort(rx_abort),
        .host_rd(host_rd), .cmd_release(cmd_release), .cmd_reset(cmd_reset),
        .rd_data(rd_data), .irq_block(irq_block), .irq_msg_end(irq_msg_end),
        .msg_done(msg_done), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .st_crc_ok(st_crc_ok), .st_abort(st_abort), .st_data_ovf(st_data_ovf)
    );

    // Watchdog: a hung run is one failed check and still ends with the summary
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one octet per cycle; optionally recorded as expected in the pool
    task automatic send_oct(input logic [7:0] b, input bit keep);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        if (keep) expq.push_back(b);
    endtask

    task automatic send_end(input bit crc, input bit ab);
        rx_end = 1'b1; rx_crc_ok = crc; rx_abort = ab;
        @(negedge clk);
        rx_end = 1'b0; rx_crc_ok = 1'b0; rx_abort = 1'b0;
    endtask

    task automatic release_pool();
        cmd_release = 1'b1;
        @(negedge clk);
        cmd_release = 1'b0;
    endtask

    // Monitor: pop expected octets and compare with the host read port
    task automatic host_read(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 8'hxx;
            chk(req, int'(rd_data), int'(e));
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7) & 8'hFF);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cnt", int'({cnt_hi, cnt_lo}), 0);
        chk("R1 flags", int'({irq_block, irq_msg_end, msg_done, st_crc_ok, st_abort, st_data_ovf}), 0);

        // R9: release with no pool occupied is ignored
        release_pool();
        chk("R9 idle release", int'(msg_done), 0);

        // Message of 40 octets: block pulse, running count, end status
        for (int i = 0; i < 40; i++) begin
            send_oct(pat(3, i), 1'b1);
            if (i == 9)  chk("R5 running cnt_lo", int'(cnt_lo), 10);
            if (i == 31) chk("R3 irq_block at 32", int'(irq_block), 1);
            if (i == 32) chk("R3 irq_block one cycle", int'(irq_block), 0);
        end
        send_end(1'b1, 1'b0);
        chk("R4 irq_msg_end", int'(irq_msg_end), 1);
        chk("R4 msg_done", int'(msg_done), 1);
        chk("R5 cnt_lo 40", int'(cnt_lo), 8'h28);
        chk("R5 cnt_hi 40", int'(cnt_hi), 0);
        chk("R7 crc latched", int'(st_crc_ok), 1);
        chk("R7 abort latched", int'(st_abort), 0);
        @(negedge clk);
        chk("R4 end pulse single", int'(irq_msg_end), 0);
        // R10: octets and end during msg_done are ignored
        for (int i = 0; i < 3; i++) send_oct(8'hEE, 1'b0);
        send_end(1'b0, 1'b1);
        chk("R10 count frozen", int'(cnt_lo), 8'h28);
        chk("R10 no end irq", int'(irq_msg_end), 0);
        chk("R10 status frozen", int'({st_crc_ok, st_abort}), 2);
        host_read(32, "R2 first block");
        release_pool();
        chk("R9 not final yet", int'(msg_done), 1);
        host_read(8, "R2 last block");
        release_pool();
        chk("R9 final release", int'(msg_done), 0);
        chk("R9 count cleared", int'({cnt_hi, cnt_lo}), 0);
        chk("R9 status cleared", int'(st_crc_ok), 0);

        // Overflow: 100 octets, host idle; octet 65 finds pool 0 occupied
        for (int i = 0; i < 100; i++) begin
            send_oct(pat(91, i), i < 64);
            if (i == 63) chk("R8 no drop yet", int'(st_data_ovf), 0);
            if (i == 64) chk("R8 drop flagged", int'(st_data_ovf), 1);
        end
        send_end(1'b0, 1'b1);
        chk("R5 cnt_lo 100", int'(cnt_lo), 8'h64);
        chk("R7 crc bad", int'(st_crc_ok), 0);
        chk("R7 abort", int'(st_abort), 1);
        host_read(32, "R8 kept pool 0");
        release_pool();
        host_read(32, "R8 kept pool 1");
        release_pool();
        chk("R9 done after overflow", int'(msg_done), 0);
        chk("R8 ovf cleared", int'(st_data_ovf), 0);

        // Saturation: 4100 octets
        for (int i = 0; i < 4100; i++) begin
            send_oct(pat(5, i), 1'b0);
            if (i == 4094) chk("R6 at 4095", int'({cnt_hi, cnt_lo}), 13'h0FFF);
            if (i == 4095) chk("R6 flag on 4096th", int'(cnt_hi), 5'h1F);
            if (i == 4099) chk("R6 held", int'({cnt_hi, cnt_lo}), 13'h1FFF);
        end
        send_end(1'b1, 1'b0);
        release_pool();
        release_pool();
        chk("R6 cleared on release", int'({cnt_hi, msg_done}), 0);

        // Exact 32-octet message: empty final pool still needs a release
        for (int i = 0; i < 32; i++) send_oct(pat(40, i), 1'b1);
        chk("R3 irq at exact 32", int'(irq_block), 1);
        send_end(1'b1, 1'b0);
        chk("R5 cnt_lo 32", int'(cnt_lo), 8'h20);
        host_read(32, "R2 exact block");
        release_pool();
        chk("R9 empty final pool pending", int'(msg_done), 1);
        release_pool();
        chk("R9 empty final pool released", int'(msg_done), 0);

        // R11: reset command discards a partial message
        for (int i = 0; i < 10; i++) send_oct(8'hA5, 1'b0);
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        chk("R1 cmd_reset count", int'({cnt_hi, cnt_lo}), 0);
        chk("R11 cmd_reset flags", int'({msg_done, st_data_ovf}), 0);
        for (int i = 0; i < 5; i++) send_oct(pat(200, i), 1'b1);
        send_end(1'b1, 1'b0);
        chk("R11 new count", int'(cnt_lo), 5);
        host_read(5, "R11 data after reset");
        release_pool();
        chk("R11 done", int'(msg_done), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule